// File: doc/BRIEF.md
# Seconds-Count Watchdog with Indexed Configuration Registers

This block is a watchdog timer that sits behind an indexed configuration port. Software picks a logical device through a select register and switches it on with an activate bit. Once the watchdog device is selected and active, three 8-bit registers become visible: a count register, a control register and a control-status register.

The count register does three jobs. Writing a nonzero value loads the count and starts the timer, and writing the same kind of value again while it runs acts as a keepalive. Writing zero halts the timer. A read returns the time still left. The count drops by one on each pulse of the 1 Hz tick input. When the count steps from one to zero, a sticky timeout flag is set in the control-status register. If the route bit in the control register is set, an active-low reset output also goes low for a fixed number of clock cycles.

Top module: `sio_wdt`

## Requirements
- R1: After reset the device select, activate bit, count, control and control-status registers are all zero, and `kbrst_no` is high.
- R2: Index 0x07 holds the logical device number and can always be read and written. Index 0x30 bit 0 is the activate bit, reachable only while the device number is 8. Indices 0xF5, 0xF6 and 0xF7 read as 0 and ignore writes unless the device number is 8 and activate is 1.
- R3: Writing a nonzero value to index 0xF6 loads it as the count. While the count is nonzero, each clock cycle with `tick_i` high lowers it by one.
- R4: Writing 0 to index 0xF6 stops the timer. A zero count stays zero whatever the ticks do.
- R5: A nonzero write to index 0xF6 while the timer runs reloads the count. When a count write and a tick fall in the same cycle, the write wins and that tick is lost.
- R6: A read of index 0xF6 returns the time left, in ticks.
- R7: A tick that takes the count from 1 to 0 sets bit 4 of index 0xF7. The bit stays set until software writes index 0xF7.
- R8: At expiry with bit 1 of index 0xF5 set, `kbrst_no` goes low for exactly 16 clock cycles, starting after the expiry edge. With that bit clear, `kbrst_no` stays high.
- R9: Indices 0xF5 and 0xF7 read back all 8 bits as last written, except where R7 sets bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_i | input | 8 | Register index |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle |
| rdata_o | output | 8 | Read data for `idx_i`, combinational |
| tick_i | input | 1 | Time-unit tick, one cycle per unit |
| kbrst_no | output | 1 | Active-low reset pulse |

## Verification
The bench tries the count with several input patterns: a plain load, a load followed by free-running ticks, a reload in mid-count, a stop followed by further ticks, and a load at full scale. Comparing the remaining time after each pattern separates load, decrement and hold behaviour. Expiry is run twice, once with the route bit set and once with it clear. Pulse width and flag are checked separately, so a missing or wrongly sized pulse is caught apart from the flag. Access gating is tested with writes made before the device is selected and after it is deselected. A write that lands in the same cycle as a tick checks the priority rule.

// File: rtl/sio_wdt_pkg.sv
package sio_wdt_pkg;
  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam logic [7:0] IDX_ACT   = 8'h30;
  localparam logic [7:0] IDX_CTRL  = 8'hF5;
  localparam logic [7:0] IDX_COUNT = 8'hF6;
  localparam logic [7:0] IDX_CSR   = 8'hF7;
  localparam logic [7:0] WDT_LDN   = 8'h08;
  localparam int CTRL_ROUTE_BIT    = 1;
  localparam int CSR_FLAG_BIT      = 4;
endpackage

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o,
  output logic          expire_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  // a write in the same cycle beats the tick
  assign expire_o = tick_i && !load_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - ONE;
  end

  assign cnt_o = cnt_q;

  a_r3_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
  a_r4_zero_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
  a_r5_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_no
);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pcnt_q <= '0;
    else if (fire_i)        pcnt_q <= PW'(PULSE_CYC);
    else if (pcnt_q != '0)  pcnt_q <= pcnt_q - PW'(1);
  end

  assign pulse_no = (pcnt_q == '0);

  a_r8_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_no) |-> $past(fire_i));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import sio_wdt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          expire_i,
  output logic          cnt_load_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] rdata_o
);
  logic [7:0]    ldn_q;
  logic          act_q;
  logic [DW-1:0] ctrl_q, csr_q;
  logic          dev_sel, access;

  assign dev_sel    = (ldn_q == WDT_LDN);
  assign access     = dev_sel && act_q;
  assign cnt_load_o = wr_i && access && (idx_i == IDX_COUNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldn_q  <= '0;
      act_q  <= 1'b0;
      ctrl_q <= '0;
      csr_q  <= '0;
    end else begin
      if (wr_i && idx_i == IDX_LDN)                ldn_q  <= wdata_i[7:0];
      if (wr_i && dev_sel && idx_i == IDX_ACT)     act_q  <= wdata_i[0];
      if (wr_i && access && idx_i == IDX_CTRL)     ctrl_q <= wdata_i;
      if (wr_i && access && idx_i == IDX_CSR)      csr_q  <= wdata_i;
      if (expire_i)                                csr_q[CSR_FLAG_BIT] <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx_i == IDX_LDN)                 rdata_o = DW'(ldn_q);
    else if (idx_i == IDX_ACT && dev_sel) rdata_o = DW'(act_q);
    else if (access) begin
      case (idx_i)
        IDX_CTRL:  rdata_o = ctrl_q;
        IDX_COUNT: rdata_o = cnt_i;
        IDX_CSR:   rdata_o = csr_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;

  a_r2_ctrl_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access |=> $stable(ctrl_q));
  a_r7_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> csr_q[CSR_FLAG_BIT]);
  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_q[CSR_FLAG_BIT] && !(wr_i && access && idx_i == IDX_CSR)) |=> csr_q[CSR_FLAG_BIT]);
endmodule

// File: rtl/sio_wdt.sv
module sio_wdt
  import sio_wdt_pkg::*;
#(
  parameter int DW        = 8,
  parameter int PULSE_CYC = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tick_i,
  output logic          kbrst_no
);
  logic [DW-1:0] cnt, ctrl;
  logic          cnt_load, expire, fire;

  wdt_regs #(.DW(DW)) i_regs (
    .clk_i, .rst_ni, .idx_i, .wdata_i, .wr_i,
    .cnt_i(cnt), .expire_i(expire),
    .cnt_load_o(cnt_load), .ctrl_o(ctrl), .rdata_o
  );

  wdt_count #(.CW(DW)) i_count (
    .clk_i, .rst_ni, .load_i(cnt_load), .load_val_i(wdata_i),
    .tick_i, .cnt_o(cnt), .expire_o(expire)
  );

  assign fire = expire && ctrl[CTRL_ROUTE_BIT];

  wdt_pulse #(.PULSE_CYC(PULSE_CYC)) i_pulse (
    .clk_i, .rst_ni, .fire_i(fire), .pulse_no(kbrst_no)
  );

  a_r8_no_route_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !ctrl[CTRL_ROUTE_BIT] && kbrst_no) |=> kbrst_no);
endmodule

// File: tb/test_sio_wdt.sv
module test_sio_wdt;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] idx = '0, wdata = '0, rdata;
  logic       wr = 1'b0, tick = 1'b0, kbrst_n;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_wdt i_sio_wdt (
    .clk_i(clk), .rst_ni(rst_n), .idx_i(idx), .wdata_i(wdata), .wr_i(wr),
    .rdata_o(rdata), .tick_i(tick), .kbrst_no(kbrst_n)
  );

  // {we, idx, data, ticks, read_idx, expected}
  localparam int NV = 9;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'hF6, 8'd10,  8'd0, 8'hF6, 8'd10},   // R3 load
    {1'b0, 8'hF6, 8'd0,   8'd3, 8'hF6, 8'd7},    // R3 R6 decrement
    {1'b1, 8'hF6, 8'd20,  8'd1, 8'hF6, 8'd19},   // R5 keepalive
    {1'b1, 8'hF6, 8'd0,   8'd5, 8'hF6, 8'd0},    // R4 stop
    {1'b1, 8'hF5, 8'h02,  8'd0, 8'hF5, 8'h02},   // R9 ctrl
    {1'b1, 8'hF6, 8'd255, 8'd2, 8'hF6, 8'd253},  // R3 full scale
    {1'b1, 8'hF6, 8'd0,   8'd0, 8'hF7, 8'h00},   // R7 no flag
    {1'b1, 8'hF7, 8'hD0,  8'd0, 8'hF7, 8'hD0},   // R9 csr
    {1'b1, 8'hF7, 8'h00,  8'd0, 8'hF7, 8'h00}    // R9 csr clear
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
    @(negedge clk); idx = i; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] i, input logic [7:0] exp, input string req);
    idx = i; #1; check(rdata, exp, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int low;
    #(CLK_PERIOD * 3); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({7'b0, kbrst_n}, 8'h01, "R1 kbrst");
    rd_chk(8'h07, 8'h00, "R1 ldn");
    // R2 writes before selection ignored
    wr_reg(8'hF6, 8'd5);
    wr_reg(8'h07, 8'h08);
    rd_chk(8'h30, 8'h00, "R1 act");
    wr_reg(8'h30, 8'h01);
    rd_chk(8'hF6, 8'h00, "R2 gated write");

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][40]) wr_reg(VEC[v][39:32], VEC[v][31:24]);
      for (int t = 0; t < int'(VEC[v][23:16]); t++) do_tick();
      @(negedge clk);
      rd_chk(VEC[v][15:8], VEC[v][7:0], $sformatf("R3-R9 vec%0d", v));
    end

    // R7 R8 expiry with route set
    wr_reg(8'hF6, 8'd2);
    do_tick();
    check({7'b0, kbrst_n}, 8'h01, "R8 no early pulse");
    do_tick();
    rd_chk(8'hF7, 8'h10, "R7 flag");
    rd_chk(8'hF6, 8'h00, "R4 count at zero");
    low = 0;
    for (int c = 0; c < 30; c++) begin
      if (!kbrst_n) low++;
      @(negedge clk);
    end
    check(8'(low), 8'd16, "R8 pulse width");
    rd_chk(8'hF7, 8'h10, "R7 sticky");

    // R8 route clear: no pulse
    wr_reg(8'hF5, 8'h00);
    wr_reg(8'hF7, 8'h00);
    wr_reg(8'hF6, 8'd1);
    do_tick();
    rd_chk(8'hF7, 8'h10, "R7 flag no route");
    low = 0;
    for (int c = 0; c < 20; c++) begin
      if (!kbrst_n) low++;
      @(negedge clk);
    end
    check(8'(low), 8'd0, "R8 route clear");

    // R5 write beats same-cycle tick
    wr_reg(8'hF7, 8'h00);
    wr_reg(8'hF6, 8'd1);
    @(negedge clk); idx = 8'hF6; wdata = 8'd1; wr = 1'b1; tick = 1'b1;
    @(negedge clk); wr = 1'b0; tick = 1'b0;
    rd_chk(8'hF6, 8'd1, "R5 write priority");
    rd_chk(8'hF7, 8'h00, "R5 no expiry");

    // R2 deselect hides and blocks registers
    wr_reg(8'h07, 8'h07);
    rd_chk(8'hF6, 8'h00, "R2 hidden");
    wr_reg(8'hF6, 8'd50);
    wr_reg(8'h07, 8'h08);
    rd_chk(8'hF6, 8'd1, "R2 blocked write");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule